// File: doc/BRIEF.md
# Multi-Region Redistributor Address Mapper

This block keeps a small table of redistributor regions and turns a physical address into a redistributor slot. A redistributor is a pair of adjacent 64 KiB pages. Software describes where these pairs live in one of two ways, and the two cannot be mixed.

In region mode, software registers up to eight regions, in order of their index. Each region holds a variable number of redistributors packed back to back. Global redistributor numbers run through the regions in index order. In legacy mode, software sets one base, and the redistributors follow it with no upper bound other than the CPU count.

A registered request port accepts four operations: register a region, read back a region, set the legacy base, and read back the legacy base. Each request gets an error code and a data word one cycle later. A combinational lookup port returns three things for any address, checked against a CPU-count input: a hit flag, the global redistributor number, and which of the two pages was addressed.

Top module: `redist_region_map`

## Requirements
- R1: `req_ready` is always 1. Every cycle with `req_valid` high produces `rsp_valid` high on the next cycle, with `rsp_err` and `rsp_word`. A cycle without a request produces no response. Error codes: OK=0, INVALID=1, EXISTS=2, NOENT=3, RANGE=4. `rsp_word` is 0 for every operation except a successful readback. Operation codes: 0 registers a region, 1 reads a region back, 2 sets the legacy base, 3 reads the legacy base.
- R2: The layout of a region word is: index in bits 11:0, a flags field in bits 15:12, address bits 51:16 of the base in bits 51:16, and the redistributor count in bits 63:52. A registration with nonzero flags or a count of zero returns INVALID.
- R3: A registration index must equal the number of regions already stored. An index below that number returns EXISTS. An index above it returns INVALID. When eight regions are already stored, any further registration returns INVALID.
- R4: A region whose end address (base + count × 128 KiB) exceeds 2^PA_BITS returns RANGE. An end exactly at 2^PA_BITS is accepted.
- R5: If any region has been stored, operations 2 and 3 return INVALID. If the legacy base has been set, operations 0 and 1 return INVALID.
- R6: Setting the legacy base is checked in this order: a second set returns EXISTS; an address with nonzero bits 15:0 returns INVALID; an address with any bit at or above PA_BITS set returns RANGE. Error checks for a region registration apply in this order: R5, then R2, then R3, then R4.
- R7: Reading back an index that is not stored returns NOENT. Reading back a stored index returns OK with a word that has count, base and index in the R2 layout and zero flags.
- R8: Reading back the legacy base returns it when it has been set, and NOENT when it has not.
- R9: In region mode, an address A inside region i (base B_i, count C_i, where S_i is the sum of the counts of regions 0..i-1) is decoded as follows: the number is S_i + (A−B_i)/128 KiB, and `lk_frame` is bit 16 of (A−B_i). If regions overlap, the lowest index wins.
- R10: `lk_hit` is 0 when the address lies in no region, or when the decoded number is at or above `cpu_count`. On a miss, `lk_num` and `lk_frame` read 0.
- R11: In legacy mode, an address A at or above base B is decoded as follows: the number is (A−B)/128 KiB, and the frame is bit 16 of (A−B). The R10 limit applies.
- R12: After reset, no region is stored and no legacy base is set: `rsp_valid` is 0, and every lookup misses.
- R13: A request that returns an error changes no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Always 1 |
| req_op | input | 2 | Operation code |
| req_word | input | 64 | Region word or legacy address |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_err | output | 3 | Error code |
| rsp_word | output | 64 | Readback data |
| cpu_count | input | 15 | Number of redistributors in use |
| lk_addr | input | 64 | Address to decode |
| lk_hit | output | 1 | Address maps to a redistributor in use |
| lk_num | output | 15 | Global redistributor number |
| lk_frame | output | 1 | Page within the redistributor |

## Verification
The properties assume two things about the inputs. First, `req_op` and `req_word` are stable when `req_valid` is sampled. Second, `cpu_count` changes only between lookups and never during a request. The stimulus drives every input on the falling edge and samples lookups before the next rising edge, so each decode sees a settled table. Regions are registered only with end addresses no larger than 2^PA_BITS. Their spans are kept disjoint, so the lowest-index rule never shadows a region the sweep expects to reach.

// File: rtl/redist_region_map.sv
module redist_region_map #(
  parameter int MAX_REGIONS = 8,
  parameter int PA_BITS     = 48,
  localparam int RI_W       = $clog2(MAX_REGIONS),
  localparam int SLOT_W     = $clog2(MAX_REGIONS + 1),
  localparam int NUM_W      = 12 + RI_W
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [63:0]      req_word,
  output logic             rsp_valid,
  output logic [2:0]       rsp_err,
  output logic [63:0]      rsp_word,
  input  logic [NUM_W-1:0] cpu_count,
  input  logic [63:0]      lk_addr,
  output logic             lk_hit,
  output logic [NUM_W-1:0] lk_num,
  output logic             lk_frame
);
  localparam logic [2:0] E_OK = 3'd0, E_INV = 3'd1, E_EXIST = 3'd2, E_NOENT = 3'd3, E_RANGE = 3'd4;
  localparam logic [1:0] OP_REG = 2'd0, OP_RDREG = 2'd1, OP_SETLEG = 2'd2, OP_RDLEG = 2'd3;
  localparam logic [64:0] PA_LIM = 65'd1 << PA_BITS;

  logic [35:0]       base_q [MAX_REGIONS];
  logic [11:0]       cnt_q  [MAX_REGIONS];
  logic [SLOT_W-1:0] nreg_q;
  logic              leg_q;
  logic [63:0]       leg_base_q;

  wire [11:0] f_cnt   = req_word[63:52];
  wire [35:0] f_base  = req_word[51:16];
  wire [3:0]  f_flags = req_word[15:12];
  wire [11:0] f_idx   = req_word[11:0];
  wire [11:0] nreg_x  = 12'(nreg_q);
  wire [64:0] reg_end = 65'({f_base, 16'b0}) + (65'(f_cnt) << 17);

  assign req_ready = 1'b1;

  logic [2:0]  err_d;
  logic [63:0] word_d;
  logic        do_reg, do_leg;

  always_comb begin
    err_d  = E_OK;
    word_d = '0;
    do_reg = 1'b0;
    do_leg = 1'b0;
    case (req_op)
      OP_REG: begin
        if (leg_q)                                   err_d = E_INV;
        else if (f_flags != 4'd0 || f_cnt == 12'd0)  err_d = E_INV;
        else if (f_idx < nreg_x)                     err_d = E_EXIST;
        else if (f_idx != nreg_x || nreg_q == SLOT_W'(MAX_REGIONS)) err_d = E_INV;
        else if (reg_end > PA_LIM)                   err_d = E_RANGE;
        else                                         do_reg = 1'b1;
      end
      OP_RDREG: begin
        if (leg_q)                 err_d = E_INV;
        else if (f_idx >= nreg_x)  err_d = E_NOENT;
        else word_d = {cnt_q[f_idx[RI_W-1:0]], base_q[f_idx[RI_W-1:0]], 4'b0, f_idx};
      end
      OP_SETLEG: begin
        if (nreg_q != '0)                    err_d = E_INV;
        else if (leg_q)                      err_d = E_EXIST;
        else if (req_word[15:0] != 16'd0)    err_d = E_INV;
        else if ((req_word >> PA_BITS) != 64'd0) err_d = E_RANGE;
        else                                 do_leg = 1'b1;
      end
      default: begin
        if (nreg_q != '0)  err_d = E_INV;
        else if (!leg_q)   err_d = E_NOENT;
        else               word_d = leg_base_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nreg_q     <= '0;
      leg_q      <= 1'b0;
      leg_base_q <= '0;
      rsp_valid  <= 1'b0;
      rsp_err    <= E_OK;
      rsp_word   <= '0;
      for (int i = 0; i < MAX_REGIONS; i++) begin
        base_q[i] <= '0;
        cnt_q[i]  <= '0;
      end
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_err  <= err_d;
        rsp_word <= word_d;
        if (do_reg) begin
          base_q[f_idx[RI_W-1:0]] <= f_base;
          cnt_q[f_idx[RI_W-1:0]]  <= f_cnt;
          nreg_q <= nreg_q + 1'b1;
        end
        if (do_leg) begin
          leg_q      <= 1'b1;
          leg_base_q <= req_word;
        end
      end
    end
  end

  logic             found, frm;
  logic [NUM_W-1:0] acc, num;
  logic [63:0]      off, rbase;

  always_comb begin
    found = 1'b0;
    frm   = 1'b0;
    num   = '0;
    acc   = '0;
    off   = '0;
    rbase = '0;
    for (int i = 0; i < MAX_REGIONS; i++) begin
      rbase = {12'b0, base_q[i], 16'b0};
      off   = lk_addr - rbase;
      if (!found && SLOT_W'(i) < nreg_q && lk_addr >= rbase && (off >> 17) < 64'(cnt_q[i])) begin
        found = 1'b1;
        num   = acc + NUM_W'(off >> 17);
        frm   = off[16];
      end
      acc = acc + NUM_W'(cnt_q[i]);
    end
    if (leg_q) begin
      off = lk_addr - leg_base_q;
      if (lk_addr >= leg_base_q && (off >> 17) < 64'(cpu_count)) begin
        found = 1'b1;
        num   = NUM_W'(off >> 17);
        frm   = off[16];
      end
    end
  end

  assign lk_hit   = found && (num < cpu_count);
  assign lk_num   = lk_hit ? num : '0;
  assign lk_frame = lk_hit & frm;
endmodule

module redist_region_map_chk #(
  parameter int NUM_W = 15
)(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_op,
  input logic [63:0]      req_word,
  input logic             rsp_valid,
  input logic [2:0]       rsp_err,
  input logic [NUM_W-1:0] cpu_count,
  input logic             lk_hit,
  input logic [NUM_W-1:0] lk_num,
  input logic             lk_frame
);
  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid);
  p_no_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid);
  p_err_legal_r1: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> rsp_err <= 3'd4);
  p_bad_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd0 && (req_word[15:12] != 4'd0 || req_word[63:52] == 12'd0)) |=> rsp_err == 3'd1);
  p_leg_misalign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd2 && req_word[15:0] != 16'd0) |=> rsp_err != 3'd0);
  p_hit_limit_r10: assert property (@(posedge clk) disable iff (!rst_n) lk_hit |-> lk_num < cpu_count);
  p_miss_zero_r10: assert property (@(posedge clk) disable iff (!rst_n) !lk_hit |-> (lk_num == '0 && !lk_frame));
endmodule

bind redist_region_map redist_region_map_chk #(.NUM_W(NUM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_word(req_word),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .cpu_count(cpu_count),
  .lk_hit(lk_hit), .lk_num(lk_num), .lk_frame(lk_frame)
);

// File: tb/redist_region_map_tb.sv
module redist_region_map_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [63:0] req_word = '0;
  logic        rsp_valid;
  logic [2:0]  rsp_err;
  logic [63:0] rsp_word;
  logic [14:0] cpu_count = '0;
  logic [63:0] lk_addr = '0;
  logic        lk_hit;
  logic [14:0] lk_num;
  logic        lk_frame;

  int n_tests = 0;
  int n_fail  = 0;

  longint unsigned mb [8];
  int              mc [8];
  int              nm = 0;
  bit              leg_on = 0;
  longint unsigned leg_b = 0;

  always #2.5 clk = ~clk;

  redist_region_map u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_word(req_word), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_word(rsp_word), .cpu_count(cpu_count), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_num(lk_num), .lk_frame(lk_frame)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rword(int cnt, longint unsigned base, int flags, int idx);
    return {12'(cnt), base[51:16], 4'(flags), 12'(idx)};
  endfunction

  task automatic do_req(string tag, logic [1:0] op, logic [63:0] w, logic [2:0] e, logic [63:0] ew);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_word = w;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, 64'(rsp_valid), 64'd1);
    check({tag, " err"}, 64'(rsp_err), 64'(e));
    check({tag, " word"}, rsp_word, ew);
  endtask

  task automatic reg_ok(int idx, int cnt, longint unsigned base);
    do_req("R3 register", 2'd0, rword(cnt, base, 0, idx), 3'd0, 64'd0);
    mb[idx] = base; mc[idx] = cnt; nm = idx + 1;
  endtask

  task automatic lookup(string tag, logic [63:0] a, logic [14:0] cpu);
    bit hit = 0; int num = 0; bit fr = 0; int acc = 0;
    for (int i = 0; i < nm; i++) begin
      if (!hit && a >= mb[i] && a < mb[i] + longint'(mc[i]) * 64'h20000) begin
        hit = 1; num = acc + int'((a - mb[i]) / 64'h20000); fr = (((a - mb[i]) / 64'h10000) % 2) == 1;
      end
      acc += mc[i];
    end
    if (leg_on && a >= leg_b && (a - leg_b) / 64'h20000 < 64'(cpu)) begin
      hit = 1; num = int'((a - leg_b) / 64'h20000); fr = (((a - leg_b) / 64'h10000) % 2) == 1;
    end
    if (num >= int'(cpu)) hit = 0;
    if (!hit) begin num = 0; fr = 0; end
    @(negedge clk);
    lk_addr = a; cpu_count = cpu;
    #1;
    check({tag, " hit"}, 64'(lk_hit), 64'(hit));
    check({tag, " num"}, 64'(lk_num), 64'(num));
    check({tag, " frame"}, 64'(lk_frame), 64'(fr));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    nm = 0; leg_on = 0; leg_b = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R12 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check("R1 ready", 64'(req_ready), 64'd1);
    lookup("R12 empty lookup", 64'h80000, 15'd8);
    @(negedge clk); #1;
    check("R1 idle no response", 64'(rsp_valid), 64'd0);
    do_req("R7 read empty", 2'd1, 64'd0, 3'd3, 64'd0);
    do_req("R8 legacy read unset", 2'd3, 64'd0, 3'd3, 64'd0);

    do_req("R2 flags set", 2'd0, rword(3, 64'h80000, 4'h5, 0), 3'd1, 64'd0);
    do_req("R2 count zero", 2'd0, rword(0, 64'h80000, 0, 0), 3'd1, 64'd0);
    do_req("R3 index skips", 2'd0, rword(3, 64'h80000, 0, 1), 3'd1, 64'd0);
    do_req("R13 nothing stored", 2'd1, 64'd0, 3'd3, 64'd0);
    reg_ok(0, 3, 64'h80000);
    do_req("R3 reuse index", 2'd0, rword(2, 64'h900000, 0, 0), 3'd2, 64'd0);
    do_req("R3 index ahead", 2'd0, rword(2, 64'h900000, 0, 2), 3'd1, 64'd0);
    do_req("R13 region0 intact", 2'd1, 64'd0, 3'd0, rword(3, 64'h80000, 0, 0));
    reg_ok(1, 2, 64'h210000);
    do_req("R4 past top", 2'd0, rword(3, 64'hFFFF_FFFC_0000, 0, 2), 3'd4, 64'd0);
    do_req("R4 base beyond", 2'd0, rword(1, 64'h1_0000_0000_0000, 0, 2), 3'd4, 64'd0);
    reg_ok(2, 2, 64'hFFFF_FFFC_0000);
    do_req("R5 legacy set in region mode", 2'd2, 64'h3000_0000, 3'd1, 64'd0);
    do_req("R5 legacy read in region mode", 2'd3, 64'd0, 3'd1, 64'd0);
    do_req("R7 readback r1", 2'd1, 64'd1, 3'd0, rword(2, 64'h210000, 0, 1));
    do_req("R7 readback r2", 2'd1, 64'd2, 3'd0, rword(2, 64'hFFFF_FFFC_0000, 0, 2));
    do_req("R7 unregistered", 2'd1, 64'd3, 3'd3, 64'd0);
    for (int k = 3; k < 8; k++) reg_ok(k, 1, 64'h100_0000 + longint'(k) * 64'h10_0000);
    do_req("R3 table full", 2'd0, rword(1, 64'h400_0000, 0, 8), 3'd1, 64'd0);
    do_req("R3 table full idx9", 2'd0, rword(1, 64'h400_0000, 0, 9), 3'd1, 64'd0);

    for (int i = 0; i < 8; i++)
      for (longint unsigned a = mb[i] - 64'h10000; a < mb[i] + longint'(mc[i]) * 64'h20000 + 64'h10000; a += 64'h8000) begin
        lookup("R9 region sweep", a, 15'd12);
        lookup("R10 limited sweep", a, 15'd4);
      end
    lookup("R10 gap", 64'h180000, 15'd12);
    lookup("R9 top page", 64'hFFFF_FFFF_0000, 15'd12);

    do_reset();
    do_req("R12 reset clears table", 2'd1, 64'd0, 3'd3, 64'd0);
    do_req("R6 misaligned", 2'd2, 64'h3000_8000, 3'd1, 64'd0);
    do_req("R6 beyond range", 2'd2, 64'h1_0000_0000_0000, 3'd4, 64'd0);
    do_req("R13 legacy unset", 2'd3, 64'd0, 3'd3, 64'd0);
    do_req("R6 set legacy", 2'd2, 64'h3000_0000, 3'd0, 64'd0);
    leg_on = 1; leg_b = 64'h3000_0000;
    do_req("R6 set again", 2'd2, 64'h5000_0000, 3'd2, 64'd0);
    do_req("R8 legacy read", 2'd3, 64'd0, 3'd0, 64'h3000_0000);
    do_req("R5 region in legacy mode", 2'd0, rword(1, 64'h80000, 0, 0), 3'd1, 64'd0);
    do_req("R5 region read in legacy mode", 2'd1, 64'd0, 3'd1, 64'd0);
    for (longint unsigned a = 64'h2FFF_0000; a < 64'h3010_0000; a += 64'h8000) begin
      lookup("R11 legacy sweep", a, 15'd3);
      lookup("R11 legacy wide", a, 15'd7);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule